// File: doc/BRIEF.md
# Multicycle Shared-Memory Processor Datapath

This block is the datapath of a small 32-bit load/store processor that runs one instruction over several clock cycles. One memory port serves both instruction fetch and data access. A single ALU does every addition, including the PC increment and the branch target. Five holding registers carry values from one cycle to the next: the instruction register, the memory data register, the two operand registers and the ALU result register. The block covers a word load, a word store, add, subtract, and, or, set-on-less-than, branch-if-equal and an absolute jump.

The block makes no sequencing decisions. An external controller drives every multiplexer select and every write enable on each cycle. The block returns the opcode and function fields of the current instruction so that the controller can choose its next step. The memory sits outside the block. The block drives the address, the write data and the read and write strobes, and it receives the read word on the same cycle.

Inside the block, a control stage turns the raw select lines and the function field into a strobe bundle. The datapath consumes that bundle. The datapath holds the register file, the ALU, sign extension and the PC update logic.

Top module: `mcCpuDatapath`

## Requirements
- R1: `memAddr` equals the PC when `addrSel`=0 and the ALU result register when `addrSel`=1. `memWdata` always equals operand register B. `memRdStrobe` follows `memRdEn` and `memWrStrobe` follows `memWrEn` in the same cycle.
- R2: The first ALU operand is the PC when `srcASel`=0 and operand register A when `srcASel`=1.
- R3: The second ALU operand depends on `srcBSel`:
  - 00 selects operand register B.
  - 01 selects the constant 4.
  - 10 selects the sign-extended instruction bits 15:0.
  - 11 selects that sign-extended value shifted left by two.
- R4: The ALU operation depends on `aluMode`:
  - 00 adds and 01 subtracts.
  - 10 and 11 take the operation from instruction bits 5:0: 100000 adds, 100010 subtracts, 100100 is bitwise and, 100101 is bitwise or, and 101010 is set-on-less-than.
  - Set-on-less-than gives 1 when the first operand is less than the second as signed values, and 0 otherwise.
  - Any other function code adds.
- R5: The next-PC value depends on `pcSel`:
  - 00 and 11 select the live ALU result.
  - 01 selects the ALU result register.
  - 10 selects the jump target. The jump target is PC bits 31:28, then instruction bits 25:0, then two zero bits.
- R6: The PC loads on a clock edge when `pcWe` is high, or when `pcWeBranch` is high and the live ALU result is zero. Otherwise the PC holds its value.
- R7: The instruction register loads the memory read word only on an edge where `irLoad` is high. `opcode` shows instruction bits 31:26 and `funct` shows instruction bits 5:0.
- R8: The following registers load on every clock edge:
  - the memory data register, from the memory read word;
  - operand register A, from the register file entry named by instruction bits 25:21;
  - operand register B, from the register file entry named by instruction bits 20:16;
  - the ALU result register, from the ALU result.
- R9: When `rfWe` is high, the register file writes one entry. The entry is instruction bits 15:11 when `dstSel`=1 and bits 20:16 when `dstSel`=0. The data is the ALU result register when `wbSel`=0 and the memory data register when `wbSel`=1.
- R10: Register entry 0 always reads as zero. A write to entry 0 has no effect.
- R11: After reset the following are all zero: the PC, the instruction register, every holding register and every register file entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrSel | input | 1 | Memory address source: 0 selects the PC, 1 selects the ALU result register |
| memRdEn | input | 1 | Memory read request from the controller |
| memWrEn | input | 1 | Memory write request from the controller |
| irLoad | input | 1 | Instruction register load enable |
| dstSel | input | 1 | Destination field select: 1 selects bits 15:11, 0 selects bits 20:16 |
| wbSel | input | 1 | Write-back data: 0 selects the ALU result register, 1 selects the memory data register |
| rfWe | input | 1 | Register file write enable |
| srcASel | input | 1 | First ALU operand select |
| srcBSel | input | 2 | Second ALU operand select |
| aluMode | input | 2 | ALU operation mode |
| pcSel | input | 2 | Next-PC source select |
| pcWe | input | 1 | Unconditional PC write |
| pcWeBranch | input | 1 | PC write when the ALU result is zero |
| memRdata | input | 32 | Word read from memory |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdStrobe | output | 1 | Memory read strobe |
| memWrStrobe | output | 1 | Memory write strobe |
| opcode | output | 6 | Instruction bits 31:26 |
| funct | output | 6 | Instruction bits 5:0 |
| pcValue | output | 32 | Current PC |

## Verification
The bench targets the following corner cases:
- A branch whose operands are equal must redirect the PC, and a branch whose operands differ must leave it alone. If the zero-gated write is wrong, the next fetch address moves to the wrong instruction.
- Loads and ALU results aimed at register 0 are followed by a store of register 0. A design that lets entry 0 be written drives a nonzero store word.
- Set-on-less-than is run with a negative operand. An unsigned compare gives the opposite bit.
- An unlisted function code is run and must add. A wrong default decode produces a different stored word.
- The jump target must keep the upper PC bits. Losing them or mis-shifting the field sends the fetch address astray.
- A long run of unconstrained select and enable patterns reaches the operand-select and PC-source codes that a normal instruction flow never combines.

// File: rtl/mcPkg.sv
package mcPkg;
  localparam int XLEN  = 32;
  localparam int REG_N = 32;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } aluOp_e;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  localparam logic [1:0] SB_REG  = 2'b00;
  localparam logic [1:0] SB_FOUR = 2'b01;
  localparam logic [1:0] SB_IMM  = 2'b10;

  localparam logic [1:0] PCS_RES  = 2'b00;
  localparam logic [1:0] PCS_HELD = 2'b01;
  localparam logic [1:0] PCS_JUMP = 2'b10;

  typedef struct packed {
    logic       addrSel;
    logic       memRd;
    logic       memWr;
    logic       irLoad;
    logic       dstSel;
    logic       wbSel;
    logic       rfWe;
    logic       srcASel;
    logic [1:0] srcBSel;
    aluOp_e     aluOp;
    logic [1:0] pcSel;
    logic       pcWe;
    logic       pcWeBranch;
  } strobes_t;
endpackage

// File: rtl/mcAlu.sv
module mcAlu
  import mcPkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluOp_e       op,
  output logic [W-1:0] res,
  output logic         zero
);
  always_comb begin
    case (op)
      ALU_SUB: res = opA - opB;
      ALU_AND: res = opA & opB;
      ALU_OR:  res = opA | opB;
      ALU_SLT: res = {{(W-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: res = opA + opB;
    endcase
  end

  assign zero = (res == '0);
endmodule

// File: rtl/mcRegFile.sv
module mcRegFile
  import mcPkg::*;
#(
  parameter int W    = XLEN,
  parameter int NREG = REG_N
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [$clog2(NREG)-1:0] rAddrA,
  input  logic [$clog2(NREG)-1:0] rAddrB,
  output logic [W-1:0]            rdA,
  output logic [W-1:0]            rdB,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wAddr,
  input  logic [W-1:0]            wData
);
  localparam int AW = $clog2(NREG);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wAddr != '0) begin
      regs[wAddr] <= wData;
    end
  end

  assign rdA = (rAddrA == AW'(0)) ? '0 : regs[rAddrA];
  assign rdB = (rAddrB == AW'(0)) ? '0 : regs[rAddrB];

  AST_RF_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    we && wAddr != '0 |=> (rAddrA != $past(wAddr)) || (rdA == $past(wData))); // R9

  AST_RF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    we && wAddr == '0 |=> (rAddrB != '0) || (rdB == '0)); // R10
endmodule

// File: rtl/mcControl.sv
module mcControl
  import mcPkg::*;
(
  input  logic       addrSel,
  input  logic       memRdEn,
  input  logic       memWrEn,
  input  logic       irLoad,
  input  logic       dstSel,
  input  logic       wbSel,
  input  logic       rfWe,
  input  logic       srcASel,
  input  logic [1:0] srcBSel,
  input  logic [1:0] aluMode,
  input  logic [1:0] pcSel,
  input  logic       pcWe,
  input  logic       pcWeBranch,
  input  logic [5:0] funct,
  output strobes_t   st
);
  aluOp_e fnOp;

  always_comb begin
    case (funct)
      FN_SUB:  fnOp = ALU_SUB;
      FN_AND:  fnOp = ALU_AND;
      FN_OR:   fnOp = ALU_OR;
      FN_SLT:  fnOp = ALU_SLT;
      default: fnOp = ALU_ADD;
    endcase
  end

  always_comb begin
    st.addrSel    = addrSel;
    st.memRd      = memRdEn;
    st.memWr      = memWrEn;
    st.irLoad     = irLoad;
    st.dstSel     = dstSel;
    st.wbSel      = wbSel;
    st.rfWe       = rfWe;
    st.srcASel    = srcASel;
    st.srcBSel    = srcBSel;
    st.pcSel      = pcSel;
    st.pcWe       = pcWe;
    st.pcWeBranch = pcWeBranch;
    case (aluMode)
      2'b00:   st.aluOp = ALU_ADD;
      2'b01:   st.aluOp = ALU_SUB;
      default: st.aluOp = fnOp;
    endcase
  end
endmodule

// File: rtl/mcDatapath.sv
module mcDatapath
  import mcPkg::*;
#(
  parameter int W    = XLEN,
  parameter int NREG = REG_N
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobes_t     st,
  input  logic [W-1:0] memRdata,
  output logic [W-1:0] memAddr,
  output logic [W-1:0] memWdata,
  output logic         memRdStrobe,
  output logic         memWrStrobe,
  output logic [5:0]   opcode,
  output logic [5:0]   funct,
  output logic [W-1:0] pcValue
);
  localparam int RAW = $clog2(NREG);
  localparam int IMMW = 16;

  logic [W-1:0] pc, ir, mdr, regA, regB, aluOut;
  logic [W-1:0] srcA, srcB, immExt, aluRes, pcNext, jumpTgt;
  logic [W-1:0] rdA, rdB, wData;
  logic [RAW-1:0] wAddr;
  logic aluZero, pcLoad;

  assign immExt  = {{(W-IMMW){ir[IMMW-1]}}, ir[IMMW-1:0]};
  assign srcA    = st.srcASel ? regA : pc;
  assign jumpTgt = {pc[W-1:28], ir[25:0], 2'b00};

  always_comb begin
    case (st.srcBSel)
      SB_REG:  srcB = regB;
      SB_FOUR: srcB = W'(4);
      SB_IMM:  srcB = immExt;
      default: srcB = immExt << 2;
    endcase
  end

  always_comb begin
    case (st.pcSel)
      PCS_HELD: pcNext = aluOut;
      PCS_JUMP: pcNext = jumpTgt;
      default:  pcNext = aluRes;
    endcase
  end

  assign pcLoad = st.pcWe | (st.pcWeBranch & aluZero);
  assign wAddr  = st.dstSel ? ir[11 +: RAW] : ir[16 +: RAW];
  assign wData  = st.wbSel ? mdr : aluOut;

  mcAlu #(.W(W)) u_alu (
    .opA (srcA),
    .opB (srcB),
    .op  (st.aluOp),
    .res (aluRes),
    .zero(aluZero)
  );

  mcRegFile #(.W(W), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rstN  (rstN),
    .rAddrA(ir[21 +: RAW]),
    .rAddrB(ir[16 +: RAW]),
    .rdA   (rdA),
    .rdB   (rdB),
    .we    (st.rfWe),
    .wAddr (wAddr),
    .wData (wData)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc     <= '0;
      ir     <= '0;
      mdr    <= '0;
      regA   <= '0;
      regB   <= '0;
      aluOut <= '0;
    end else begin
      if (pcLoad)    pc <= pcNext;
      if (st.irLoad) ir <= memRdata;
      mdr    <= memRdata;
      regA   <= rdA;
      regB   <= rdB;
      aluOut <= aluRes;
    end
  end

  assign memAddr     = st.addrSel ? aluOut : pc;
  assign memWdata    = regB;
  assign memRdStrobe = st.memRd;
  assign memWrStrobe = st.memWr;
  assign opcode      = ir[31:26];
  assign funct       = ir[5:0];
  assign pcValue     = pc;

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !st.irLoad |=> $stable(ir)); // R7

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !st.pcWe && !st.pcWeBranch |=> $stable(pc)); // R6

  AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    st.pcWeBranch && aluZero && st.pcSel == PCS_HELD |=> pc == $past(aluOut)); // R6

  AST_JUMP_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    st.pcWe && st.pcSel == PCS_JUMP |=> pc[1:0] == 2'b00 && pc[W-1:28] == $past(pc[W-1:28])); // R5

  AST_MDR_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> mdr == $past(memRdata)); // R8

  AST_SLT_BIT: assert property (@(posedge clk) disable iff (!rstN)
    st.aluOp == ALU_SLT |-> aluRes[W-1:1] == '0); // R4
endmodule

// File: rtl/mcCpuDatapath.sv
module mcCpuDatapath
  import mcPkg::*;
#(
  parameter int W    = XLEN,
  parameter int NREG = REG_N
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         addrSel,
  input  logic         memRdEn,
  input  logic         memWrEn,
  input  logic         irLoad,
  input  logic         dstSel,
  input  logic         wbSel,
  input  logic         rfWe,
  input  logic         srcASel,
  input  logic [1:0]   srcBSel,
  input  logic [1:0]   aluMode,
  input  logic [1:0]   pcSel,
  input  logic         pcWe,
  input  logic         pcWeBranch,
  input  logic [W-1:0] memRdata,
  output logic [W-1:0] memAddr,
  output logic [W-1:0] memWdata,
  output logic         memRdStrobe,
  output logic         memWrStrobe,
  output logic [5:0]   opcode,
  output logic [5:0]   funct,
  output logic [W-1:0] pcValue
);
  strobes_t st;

  mcControl u_ctl (
    .addrSel   (addrSel),
    .memRdEn   (memRdEn),
    .memWrEn   (memWrEn),
    .irLoad    (irLoad),
    .dstSel    (dstSel),
    .wbSel     (wbSel),
    .rfWe      (rfWe),
    .srcASel   (srcASel),
    .srcBSel   (srcBSel),
    .aluMode   (aluMode),
    .pcSel     (pcSel),
    .pcWe      (pcWe),
    .pcWeBranch(pcWeBranch),
    .funct     (funct),
    .st        (st)
  );

  mcDatapath #(.W(W), .NREG(NREG)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memRdStrobe(memRdStrobe),
    .memWrStrobe(memWrStrobe),
    .opcode     (opcode),
    .funct      (funct),
    .pcValue    (pcValue)
  );
endmodule

// File: tb/mcCpuDatapath_bench.sv
`timescale 1ns/1ps
module mcCpuDatapath_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrSel = 0, memRdEn = 0, memWrEn = 0, irLoad = 0, dstSel = 0, wbSel = 0;
  logic rfWe = 0, srcASel = 0, pcWe = 0, pcWeBranch = 0;
  logic [1:0] srcBSel = 0, aluMode = 0, pcSel = 0;
  logic [31:0] memRdata, memAddr, memWdata, pcValue;
  logic memRdStrobe, memWrStrobe;
  logic [5:0] opcode, funct;

  always #2.5 clk = ~clk;

  mcCpuDatapath u_mcCpuDatapath (
    .clk(clk), .rstN(rstN), .addrSel(addrSel), .memRdEn(memRdEn), .memWrEn(memWrEn),
    .irLoad(irLoad), .dstSel(dstSel), .wbSel(wbSel), .rfWe(rfWe), .srcASel(srcASel),
    .srcBSel(srcBSel), .aluMode(aluMode), .pcSel(pcSel), .pcWe(pcWe),
    .pcWeBranch(pcWeBranch), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .memRdStrobe(memRdStrobe), .memWrStrobe(memWrStrobe),
    .opcode(opcode), .funct(funct), .pcValue(pcValue)
  );

  // environment memory (64 words) and the reference model's own copy
  logic [31:0] envMem [64];
  logic [31:0] refMem [64];
  assign memRdata = envMem[memAddr[7:2]];
  always @(posedge clk) if (memWrStrobe) envMem[memAddr[7:2]] <= memWdata;

  // reference state
  logic [31:0] rPc, rIr, rMdr, rA, rB, rOut;
  logic [31:0] rRegs [32];
  int vectors = 0;
  int misses = 0;
  bit done = 0;
  string curTag = "R11";

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL [%s] %s actual=%h expected=%h at %0t", curTag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] encR(int rs, int rt, int rd, logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  // compare outputs with the model, then advance the model by one edge
  task automatic stepModel();
    logic [31:0] addr, md, imm, opA, opB, res, nA, nB, wd;
    logic [5:0] fn;
    logic [4:0] wa;
    addr = addrSel ? rOut : rPc;
    chk("R1 memAddr", memAddr, addr);
    chk("R1 memWdata", memWdata, rB);
    chk("R1 strobes", {30'd0, memRdStrobe, memWrStrobe}, {30'd0, memRdEn, memWrEn});
    chk("R6 pcValue", pcValue, rPc);
    chk("R7 opcode/funct", {20'd0, opcode, funct}, {20'd0, rIr[31:26], rIr[5:0]});
    md  = refMem[addr[7:2]];
    imm = {{16{rIr[15]}}, rIr[15:0]};
    opA = srcASel ? rA : rPc;
    case (srcBSel)
      2'd0: opB = rB;
      2'd1: opB = 32'd4;
      2'd2: opB = imm;
      default: opB = imm << 2;
    endcase
    fn = rIr[5:0];
    if (aluMode == 2'd0) res = opA + opB;
    else if (aluMode == 2'd1) res = opA - opB;
    else if (fn == 6'h22) res = opA - opB;
    else if (fn == 6'h24) res = opA & opB;
    else if (fn == 6'h25) res = opA | opB;
    else if (fn == 6'h2A) res = ($signed(opA) < $signed(opB)) ? 32'd1 : 32'd0;
    else res = opA + opB;
    nA = rRegs[rIr[25:21]];
    nB = rRegs[rIr[20:16]];
    wa = dstSel ? rIr[15:11] : rIr[20:16];
    wd = wbSel ? rMdr : rOut;
    if (rfWe && wa != 0) rRegs[wa] = wd;
    if (memWrEn) refMem[addr[7:2]] = rB;
    if (pcWe || (pcWeBranch && res == 0)) begin
      if (pcSel == 2'd1) rPc = rOut;
      else if (pcSel == 2'd2) rPc = {rPc[31:28], rIr[25:0], 2'b00};
      else rPc = res;
    end
    if (irLoad) rIr = md;
    rMdr = md; rA = nA; rB = nB; rOut = res;
  endtask

  task automatic ctl(bit aS, bit mR, bit mW, bit irL, bit dS, bit wS, bit rW, bit sA,
                     bit [1:0] sB, bit [1:0] aM, bit [1:0] pS, bit pW, bit pB);
    @(negedge clk);
    addrSel = aS; memRdEn = mR; memWrEn = mW; irLoad = irL; dstSel = dS; wbSel = wS;
    rfWe = rW; srcASel = sA; srcBSel = sB; aluMode = aM; pcSel = pS; pcWe = pW; pcWeBranch = pB;
    #1;
    stepModel();
  endtask

  task automatic fetchDecode();
    ctl(0,1,0,1,0,0,0,0,2'd1,2'd0,2'd0,1,0);  // R3 constant four, R5 live result
    ctl(0,0,0,0,0,0,0,0,2'd3,2'd0,2'd0,0,0);  // R3 shifted immediate
  endtask
  task automatic doLw();
    curTag = "R8 R9 lw"; fetchDecode();
    ctl(0,0,0,0,0,0,0,1,2'd2,2'd0,2'd0,0,0);
    ctl(1,1,0,0,0,0,0,0,2'd0,2'd0,2'd0,0,0);
    ctl(0,0,0,0,0,1,1,0,2'd0,2'd0,2'd0,0,0);
  endtask
  task automatic doSw();
    curTag = "R1 R10 sw"; fetchDecode();
    ctl(0,0,0,0,0,0,0,1,2'd2,2'd0,2'd0,0,0);
    ctl(1,0,1,0,0,0,0,0,2'd0,2'd0,2'd0,0,0);
  endtask
  task automatic doR();
    curTag = "R2 R4 R9 alu"; fetchDecode();
    ctl(0,0,0,0,0,0,0,1,2'd0,2'd2,2'd0,0,0);
    ctl(0,0,0,0,1,0,1,0,2'd0,2'd0,2'd0,0,0);
  endtask
  task automatic doBeq();
    curTag = "R5 R6 beq"; fetchDecode();
    ctl(0,0,0,0,0,0,0,1,2'd0,2'd1,2'd1,0,1);
  endtask
  task automatic doJ();
    curTag = "R5 jump"; fetchDecode();
    ctl(0,0,0,0,0,0,0,0,2'd0,2'd0,2'd2,1,0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      misses++;
      $display("FAIL [watchdog] run did not finish actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) envMem[i] = 32'd0;
    envMem[0]  = encI(6'h23, 0, 1, 16'h00A0);
    envMem[1]  = encI(6'h23, 0, 2, 16'h00A4);
    envMem[2]  = encI(6'h23, 0, 3, 16'h00A8);
    envMem[3]  = encR(1, 2, 4, 6'h20);
    envMem[4]  = encR(1, 2, 5, 6'h22);
    envMem[5]  = encR(3, 2, 6, 6'h24);
    envMem[6]  = encR(3, 1, 7, 6'h25);
    envMem[7]  = encR(2, 1, 8, 6'h2A);
    envMem[8]  = encR(1, 2, 9, 6'h2A);
    envMem[9]  = encI(6'h23, 0, 0, 16'h00A0);
    envMem[10] = encR(1, 1, 0, 6'h20);
    envMem[11] = encI(6'h2B, 0, 0, 16'h00B0);
    envMem[12] = encI(6'h04, 4, 0, 16'h0002);
    envMem[13] = encR(1, 1, 10, 6'h20);
    envMem[15] = encI(6'h04, 1, 2, 16'h0005);
    envMem[16] = encI(6'h2B, 0, 5, 16'h00B4);
    envMem[17] = {6'h02, 26'd20};
    envMem[18] = encR(1, 1, 11, 6'h20);
    envMem[20] = encI(6'h2B, 0, 8, 16'h00B8);
    envMem[21] = encR(1, 3, 12, 6'h00);
    envMem[22] = encI(6'h2B, 0, 12, 16'h00BC);
    envMem[23] = encI(6'h23, 0, 13, 16'h00B4);
    envMem[24] = encI(6'h2B, 0, 13, 16'h00C0);
    envMem[40] = 32'h0000_0007;
    envMem[41] = 32'hFFFF_FFF9;
    envMem[42] = 32'h0F0F_00FF;
    for (int i = 0; i < 64; i++) refMem[i] = envMem[i];
    for (int i = 0; i < 32; i++) rRegs[i] = 32'd0;
    rPc = 0; rIr = 0; rMdr = 0; rA = 0; rB = 0; rOut = 0;

    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    curTag = "R11 reset";
    chk("R11 pc", pcValue, 32'd0);
    chk("R11 ir fields", {20'd0, opcode, funct}, 32'd0);
    chk("R11 B reg", memWdata, 32'd0);

    doLw(); doLw(); doLw();                 // words 0..2
    doR(); doR(); doR(); doR();             // add, sub, and, or
    doR(); doR();                           // slt negative vs positive, R4
    curTag = "R10 r0 load"; doLw();         // load into r0 is dropped
    doR();                                  // add into r0 is dropped, R10
    doSw();                                 // store r0: word must be zero, R10
    doBeq();                                // taken, R6
    doBeq();                                // not taken at word 15, R6
    doSw();
    doJ();                                  // to word 20, R5
    doSw();
    doR();                                  // unlisted funct adds, R4
    doSw(); doLw(); doSw();
    chk("R4 stored slt", refMem[46], 32'd1);
    chk("R10 stored r0", refMem[44], 32'd0);

    curTag = "R2 R3 R4 R5 R6 R7 R9 random";
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      ctl(r[0], r[1], r[2], r[3], r[4], r[5], r[6], r[7], r[9:8], r[11:10], r[13:12], r[14] & r[15], r[16]);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule